// File: doc/BRIEF.md
# PCI Agent Bus Handshake and Target Lock Controller

This block sits on the bus side of a PCI agent that acts both as initiator and as target. As target it answers an access that hits its address decode by claiming the cycle with DEVSEL and then, after a fixed number of initial wait states, asserting TRDY for every data phase until the initiator ends the burst. It watches the bus IRDY and TRDY lines and emits a one-cycle pulse for every completed data phase, whichever side owns the transfer.

The target can be locked by any master through the LOCK line. While it is locked, a different initiator, identified by the initiator ID input, is turned away with a retry: DEVSEL and STOP with TRDY held off. The lock owner keeps normal access until the bus shows both FRAME and LOCK idle. On the initiator side the block raises REQ when the agent needs the bus. Once raised, REQ is held until GNT is seen, even when a stop, sleep or soft-reset request arrives later.

All bus lines are presented to the block as active-high levels; pad inversion lives outside. The asynchronous reset is applied at once and released through a short synchroniser.

Top module: `pcih_bus_ctrl`

## Requirements
- R1: While rst_ni is low, req_o, devsel_o, stop_o, trdy_o and done_o are all 0. Internal state stays in reset until the second rising clock edge after rst_ni rises and first updates on the third.
- R2: When req_o is 0, bus_need_i is 1, gnt_i is 0 and none of stop_req_i, sleep_i and srst_i is 1 at a rising edge, req_o is 1 from that edge on.
- R3: Once req_o is 1 it stays 1 at every edge where gnt_i is 0, whatever stop_req_i, sleep_i, srst_i and bus_need_i do.
- R4: At an edge where gnt_i is 1, req_o becomes 0.
- R5: An address phase is an edge where frame_i is 1 and it was 0 at the previous edge. If hit_i is 1 there and no retry applies, devsel_o is 1 from that edge on. trdy_o follows TGT_WAIT edges later (default 2), with stop_o at 0.
- R6: A normal target access ends, with devsel_o and trdy_o back to 0, after the edge where trdy_o, irdy_i are 1 and frame_i is 0.
- R7: done_o is 1 for exactly the cycle after each edge where irdy_i and trdy_i (the bus TRDY) are both 1.
- R8: A lock is taken by an access that gets a normal response, has lock_i at 0 at its address phase and lock_i at 1 at the next edge. The owner is the init_id_i value seen at that address phase.
- R9: While locked, an address phase that hits with an init_id_i different from the owner gets devsel_o and stop_o at 1 and trdy_o at 0 from that edge. This holds until the edge where irdy_i is 1 and frame_i is 0.
- R10: While locked, the owner's accesses get the normal response of R5.
- R11: The lock is dropped at an edge where frame_i and lock_i are both 0. After that, any initiator gets the normal response.
- R12: An address phase with hit_i at 0 leaves devsel_o, trdy_o and stop_o at 0.
- R13: With stop_req_i, sleep_i or srst_i at 1, bus_need_i cannot raise req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| frame_i | input | 1 | Bus FRAME, active high |
| irdy_i | input | 1 | Bus IRDY, active high |
| trdy_i | input | 1 | Bus TRDY as seen on the bus, active high |
| lock_i | input | 1 | Bus LOCK, active high |
| gnt_i | input | 1 | Arbiter grant, active high |
| hit_i | input | 1 | Address decode hit, valid at the address phase |
| init_id_i | input | ID_W | Identity of the current initiator |
| bus_need_i | input | 1 | Agent wants to become bus master |
| stop_req_i | input | 1 | Stop command |
| sleep_i | input | 1 | Sleep request |
| srst_i | input | 1 | Soft-reset access strobe |
| req_o | output | 1 | Bus request |
| devsel_o | output | 1 | Target claims the cycle |
| stop_o | output | 1 | Target stop (retry while locked) |
| trdy_o | output | 1 | Target ready driven by this block |
| done_o | output | 1 | One-cycle pulse per completed data phase |

## Verification
Every output is a register, so each result is due one clock after the edge that samples its cause. That holds for REQ after need or grant, DEVSEL/STOP after the address phase, the done pulse after IRDY and TRDY coincide, and the release after the final phase. TRDY alone comes TGT_WAIT edges after DEVSEL. The bench keeps a behavioural model that advances on the same rising edge as the design and compares all five outputs on the falling edge. Stimulus changes one nanosecond after that falling edge, so no comparison ever straddles an update. Directed checks sample the same falling edge, after the scenario step that should have produced the result.

// File: rtl/pcih_pkg.sv
package pcih_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_WAIT  = 2'd1,
    TS_DATA  = 2'd2,
    TS_RETRY = 2'd3
  } tgt_state_e;
endpackage

// File: rtl/pcih_rst_sync.sv
module pcih_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = shift_q[STAGES-1];
endmodule

// File: rtl/pcih_req_ctrl.sv
module pcih_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic need_i,
  input  logic gnt_i,
  input  logic stop_req_i,
  input  logic sleep_i,
  input  logic srst_i,
  output logic req_o
);
  logic req_q, req_d, blocked;

  assign blocked = stop_req_i | sleep_i | srst_i;

  // once raised, only the grant clears the request
  always_comb begin
    if (req_q) req_d = ~gnt_i;
    else       req_d = need_i & ~blocked & ~gnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/pcih_lock_trk.sv
module pcih_lock_trk #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_i,
  input  logic            hit_i,
  input  logic            frame_i,
  input  logic            lock_i,
  input  logic [ID_W-1:0] init_id_i,
  output logic            retry_o
);
  logic            locked_q, pend_q;
  logic [ID_W-1:0] owner_q, pend_id_q;
  logic            foreign;

  assign foreign = locked_q & (init_id_i != owner_q);
  assign retry_o = foreign;

  // pending: address phase seen with LOCK idle on a normal access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_id_q <= '0;
    end else begin
      pend_q <= addr_i & hit_i & ~lock_i & ~foreign;
      if (addr_i) pend_id_q <= init_id_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else if (pend_q && lock_i) begin
      locked_q <= 1'b1;
      owner_q  <= pend_id_q;
    end else if (locked_q && !frame_i && !lock_i) begin
      locked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pcih_tgt_fsm.sv
module pcih_tgt_fsm
  import pcih_pkg::*;
#(
  parameter int unsigned TGT_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_i,
  input  logic hit_i,
  input  logic retry_i,
  input  logic frame_i,
  input  logic irdy_i,
  output logic devsel_o,
  output logic trdy_o,
  output logic stop_o
);
  localparam int unsigned CNT_W = (TGT_WAIT > 1) ? $clog2(TGT_WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((TGT_WAIT > 0) ? TGT_WAIT - 1 : 0);

  tgt_state_e state_q, state_d, claim_st;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (TGT_WAIT == 0) begin : g_no_wait
      assign claim_st = TS_DATA;
    end else begin : g_wait
      assign claim_st = TS_WAIT;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      TS_IDLE: begin
        cnt_d = '0;
        if (addr_i && hit_i) state_d = retry_i ? TS_RETRY : claim_st;
      end
      TS_WAIT: begin
        if (cnt_q == CNT_LAST) state_d = TS_DATA;
        else                   cnt_d = cnt_q + 1'b1;
      end
      TS_DATA:  if (irdy_i && !frame_i) state_d = TS_IDLE;
      TS_RETRY: if (irdy_i && !frame_i) state_d = TS_IDLE;
      default:  state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign devsel_o = (state_q != TS_IDLE);
  assign trdy_o   = (state_q == TS_DATA);
  assign stop_o   = (state_q == TS_RETRY);
endmodule

// File: rtl/pcih_bus_ctrl.sv
module pcih_bus_ctrl #(
  parameter int unsigned ID_W        = 4,
  parameter int unsigned TGT_WAIT    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic            irdy_i,
  input  logic            trdy_i,
  input  logic            lock_i,
  input  logic            gnt_i,
  input  logic            hit_i,
  input  logic [ID_W-1:0] init_id_i,
  input  logic            bus_need_i,
  input  logic            stop_req_i,
  input  logic            sleep_i,
  input  logic            srst_i,
  output logic            req_o,
  output logic            devsel_o,
  output logic            stop_o,
  output logic            trdy_o,
  output logic            done_o
);
  logic rst_n_int, frame_q, done_q, addr_ph, retry;

  pcih_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n_int)
  );

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      frame_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      frame_q <= frame_i;
      done_q  <= irdy_i & trdy_i;
    end
  end

  assign addr_ph = frame_i & ~frame_q;
  assign done_o  = done_q;

  pcih_req_ctrl u_req (
    .clk_i(clk_i), .rst_ni(rst_n_int), .need_i(bus_need_i), .gnt_i(gnt_i),
    .stop_req_i(stop_req_i), .sleep_i(sleep_i), .srst_i(srst_i), .req_o(req_o)
  );

  pcih_lock_trk #(.ID_W(ID_W)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_n_int), .addr_i(addr_ph), .hit_i(hit_i),
    .frame_i(frame_i), .lock_i(lock_i), .init_id_i(init_id_i), .retry_o(retry)
  );

  pcih_tgt_fsm #(.TGT_WAIT(TGT_WAIT)) u_tgt (
    .clk_i(clk_i), .rst_ni(rst_n_int), .addr_i(addr_ph), .hit_i(hit_i),
    .retry_i(retry), .frame_i(frame_i), .irdy_i(irdy_i),
    .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o)
  );
endmodule

// File: rtl/pcih_checker.sv
module pcih_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_i,
  input logic irdy_i,
  input logic trdy_i,
  input logic req_o,
  input logic devsel_o,
  input logic stop_o,
  input logic trdy_o,
  input logic done_o
);
  AST_RST_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !(req_o || devsel_o || stop_o || trdy_o || done_o)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o); // R3

  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |=> !req_o); // R4

  AST_TRDY_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |-> devsel_o); // R5

  AST_RETRY_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (devsel_o && !trdy_o)); // R9

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(irdy_i && trdy_i)); // R7
endmodule

bind pcih_bus_ctrl pcih_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gnt_i(gnt_i), .irdy_i(irdy_i),
  .trdy_i(trdy_i), .req_o(req_o), .devsel_o(devsel_o), .stop_o(stop_o),
  .trdy_o(trdy_o), .done_o(done_o)
);

// File: tb/tb_pcih_bus_ctrl.sv
`timescale 1ns/1ps
module tb_pcih_bus_ctrl;
  localparam int ID_W = 4;
  localparam int TW   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic frame_i = 0, irdy_i = 0, lock_i = 0, gnt_i = 0, hit_i = 0;
  logic ext_trdy = 0, bus_need_i = 0, stop_req_i = 0, sleep_i = 0, srst_i = 0;
  logic [ID_W-1:0] init_id_i = '0;
  logic req_o, devsel_o, stop_o, trdy_o, done_o, bus_trdy;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  assign bus_trdy = trdy_o | ext_trdy;

  pcih_bus_ctrl #(.ID_W(ID_W), .TGT_WAIT(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .irdy_i(irdy_i),
    .trdy_i(bus_trdy), .lock_i(lock_i), .gnt_i(gnt_i), .hit_i(hit_i),
    .init_id_i(init_id_i), .bus_need_i(bus_need_i), .stop_req_i(stop_req_i),
    .sleep_i(sleep_i), .srst_i(srst_i), .req_o(req_o), .devsel_o(devsel_o),
    .stop_o(stop_o), .trdy_o(trdy_o), .done_o(done_o)
  );

  // behavioural reference
  int m_sc, m_st, m_cnt, m_owner, m_pid;
  bit m_fprev, m_req, m_done, m_locked, m_pend;

  function automatic bit m_devsel(); return m_st != 0; endfunction
  function automatic bit m_trdy();   return m_st == 2; endfunction
  function automatic bit m_stop();   return m_st == 3; endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sc = 0; m_st = 0; m_cnt = 0; m_owner = 0; m_pid = 0;
      m_fprev = 0; m_req = 0; m_done = 0; m_locked = 0; m_pend = 0;
    end else if (m_sc < 2) begin
      m_sc = m_sc + 1;
    end else begin
      bit addr, foreign, n_locked, n_pend;
      int n_owner, n_st;
      addr    = frame_i && !m_fprev;
      foreign = m_locked && (int'(init_id_i) != m_owner);
      m_done  = irdy_i && (m_trdy() || ext_trdy);
      if (m_req) m_req = !gnt_i;
      else m_req = bus_need_i && !stop_req_i && !sleep_i && !srst_i && !gnt_i;
      n_locked = m_locked; n_owner = m_owner;
      if (m_pend && lock_i) begin n_locked = 1; n_owner = m_pid; end
      else if (m_locked && !frame_i && !lock_i) n_locked = 0;
      n_pend = addr && hit_i && !lock_i && !foreign;
      if (addr) m_pid = int'(init_id_i);
      n_st = m_st;
      case (m_st)
        0: if (addr && hit_i) begin
             n_st = foreign ? 3 : (TW == 0 ? 2 : 1);
             m_cnt = 0;
           end
        1: if (m_cnt == TW - 1) n_st = 2; else m_cnt = m_cnt + 1;
        default: if (irdy_i && !frame_i) n_st = 0;
      endcase
      m_st = n_st; m_locked = n_locked; m_owner = n_owner; m_pend = n_pend;
      m_fprev = frame_i;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R3", "req_o vs model", int'(req_o), int'(m_req));
    chk("R5", "devsel_o vs model", int'(devsel_o), int'(m_devsel()));
    chk("R6", "trdy_o vs model", int'(trdy_o), int'(m_trdy()));
    chk("R9", "stop_o vs model", int'(stop_o), int'(m_stop()));
    chk("R7", "done_o vs model", int'(done_o), int'(m_done));
    if (cyc > 20000) begin
      chk("WDOG", "watchdog expired", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // one target access; keeps lock_i at lk_after once the address phase is over
  task automatic access(input int id, input bit lk_first, input bit lk_after,
                        input int phases, output bit saw_trdy, output bit saw_stop);
    int left;
    saw_trdy = 0; saw_stop = 0;
    init_id_i = ID_W'(id); hit_i = 1; frame_i = 1; irdy_i = 0; lock_i = lk_first;
    step();
    hit_i = 0; lock_i = lk_after;
    left = phases;
    for (int k = 0; k < 30 && left > 0; k++) begin
      bit t, s;
      t = trdy_o; s = stop_o;
      saw_trdy |= t; saw_stop |= s;
      frame_i = (left > 1) && !s;
      irdy_i  = 1;
      step();
      if (s) left = 0;
      else if (t) left--;
    end
    frame_i = 0; irdy_i = 0;
    step();
  endtask

  initial begin
    bit st, ss;
    #1 rst_ni = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R1", "outputs in reset", int'({req_o, devsel_o, stop_o, trdy_o, done_o}), 0);
    end
    // need raised during reset must not appear until internal reset lifts
    bus_need_i = 1;
    rst_ni = 1;
    step();
    chk("R1", "req held in sync reset", int'(req_o), 0);
    step();
    chk("R1", "req still held at 2nd edge", int'(req_o), 0);
    step();
    chk("R2", "req raised", int'(req_o), 1);
    bus_need_i = 0; stop_req_i = 1; step();
    sleep_i = 1; step();
    srst_i = 1; step(2);
    chk("R3", "req kept under stop/sleep/srst", int'(req_o), 1);
    gnt_i = 1; step();
    chk("R4", "req dropped on grant", int'(req_o), 0);
    gnt_i = 0; bus_need_i = 1; step(2);
    chk("R13", "blocked request", int'(req_o), 0);
    stop_req_i = 0; sleep_i = 0; step();
    chk("R13", "still blocked by srst", int'(req_o), 0);
    srst_i = 0; step();
    chk("R2", "req after unblock", int'(req_o), 1);
    bus_need_i = 0; gnt_i = 1; step(); gnt_i = 0; step();

    // plain access, no lock
    init_id_i = 1; hit_i = 1; frame_i = 1; step();
    hit_i = 0;
    chk("R5", "devsel after address phase", int'(devsel_o), 1);
    chk("R5", "no trdy yet", int'(trdy_o), 0);
    irdy_i = 1; step(TW);
    chk("R5", "trdy after wait states", int'(trdy_o), 1);
    frame_i = 0; step();
    chk("R6", "devsel released", int'(devsel_o), 0);
    chk("R7", "done after last phase", int'(done_o), 1);
    irdy_i = 0; step();
    chk("R7", "done single pulse", int'(done_o), 0);

    access(2, 0, 0, 3, st, ss);
    chk("R5", "multi-phase normal", int'({st, ss}), 2);

    // take lock by id 3, hold LOCK
    access(3, 0, 1, 2, st, ss);
    chk("R8", "locking access normal", int'({st, ss}), 2);
    access(5, 1, 1, 2, st, ss);
    chk("R9", "foreign master retried", int'({st, ss}), 1);
    chk("R8", "lock held so retry seen", int'(ss), 1);
    access(3, 0, 1, 2, st, ss);
    chk("R10", "owner access while locked", int'({st, ss}), 2);
    access(6, 1, 1, 1, st, ss);
    chk("R9", "second foreign retried", int'(ss), 1);
    lock_i = 0; step(2);
    access(5, 0, 0, 2, st, ss);
    chk("R11", "access after release", int'({st, ss}), 2);

    // no hit
    init_id_i = 4; hit_i = 0; frame_i = 1; irdy_i = 1; step(4);
    chk("R12", "no claim without hit", int'({devsel_o, trdy_o, stop_o}), 0);
    frame_i = 0; step(); irdy_i = 0; step();

    // initiator side data phase with another target's TRDY
    irdy_i = 1; ext_trdy = 0; step();
    chk("R7", "no done without trdy", int'(done_o), 0);
    ext_trdy = 1; step();
    chk("R7", "done as initiator", int'(done_o), 1);
    irdy_i = 0; ext_trdy = 0; step(2);

    // reset mid-run clears everything
    bus_need_i = 1; step(); bus_need_i = 0;
    rst_ni = 0; step();
    chk("R1", "outputs cleared by reset", int'({req_o, devsel_o, stop_o, trdy_o, done_o}), 0);
    rst_ni = 1; step(4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule